// File: doc/BRIEF.md
# Flash Word Write Controller

This block sits between a byte-wide register bus and a flash array that is programmed one 16-bit word at a time. Software, or a DMA engine, sets a start bit, loads a starting word address, and then streams data bytes into a single data register. The controller pairs every two bytes into one word, fires one program strobe per word towards the array, and advances the word address after each word completes. Whenever it can accept a fresh word it raises a DMA request tagged with the flash trigger number.

A watchdog guards the data stream. The bytes of each word must arrive within a fixed window that opens when the sequence starts or when the previous word finishes programming. If the window closes first, the sequence aborts and the address registers keep the address of the word that was not written, so software can restart from exactly that point.

Top module: `flash_word_writer`

## Requirements
- R1: Register offsets are 0 = control, 1 = data (write-only, reads 0), 2 = word address bits [7:0], 3 = word address bits [15:8]; control bit 0 is the start bit and bit 1 is the word-busy flag; all read 0 after reset.
- R2: Writing control with bit 0 = 1 starts a sequence: bit 0 reads 1, and `dma_req` goes high with `dma_trig` = 5'b10010 (it is 5'b00000 whenever `dma_req` is low).
- R3: The first data byte of a pair becomes bits [7:0] and the second bits [15:8] of a word; the second byte produces exactly one `fl_prog` pulse carrying that word and the current word address.
- R4: Word-busy reads 1 for PROG_CYCLES cycles after each strobe; `dma_req` is low while word-busy is high and while half a word is held.
- R5: When a word finishes, the word address increments by one, carrying from the low into the high address register.
- R6: Data bytes written while word-busy is high or while no sequence is active are dropped: no strobe results and the byte pairing is not advanced.
- R7: If a word is not completed within TMO_CYCLES cycles of the start or of word-busy falling, the sequence aborts: bit 0 reads 0 and the address registers keep the address of the unwritten word.
- R8: Setting the start bit again after an abort resumes at the retained address with the byte pairing reset, so a stray half word is discarded.
- R9: Writing control with bit 0 = 0 ends the sequence only while word-busy is low; during word-busy that write is ignored.
- R10: Writes to the address registers are ignored while a sequence is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational) |
| fl_prog | output | 1 | One-cycle program strobe to the array |
| fl_addr | output | 16 | Word address being programmed |
| fl_data | output | 16 | Word data being programmed |
| dma_req | output | 1 | Ready for a new word |
| dma_trig | output | 5 | Trigger number, 5'b10010 when requesting |

## Verification
The bench builds the controller with TMO_CYCLES = 60 and PROG_CYCLES = 6 instead of the roughly ten thousand cycles that 40 µs takes at 250 MHz. The short window lets a run reach both timeout aborts (half a word pending, and no data after a completed word) and the following resume within a few hundred cycles. The short program time makes it cheap to poke the data and control registers while word-busy is high and to watch an address carry from the low into the high register.

// File: rtl/fww_pkg.sv
// Shared constants of the flash word write controller.
// Assumes an 8-bit register bus with four offsets.
package fww_pkg;
    localparam logic [1:0] REG_CTRL    = 2'd0;
    localparam logic [1:0] REG_DATA    = 2'd1;
    localparam logic [1:0] REG_ADDR_LO = 2'd2;
    localparam logic [1:0] REG_ADDR_HI = 2'd3;
    localparam int CTRL_GO_BIT    = 0;
    localparam int CTRL_WBUSY_BIT = 1;
    localparam logic [4:0] DMA_TRIG_FLASH = 5'b10010;
endpackage

// File: rtl/fww_pair.sv
// Byte pairing: holds the first byte of a word, and on the second byte
// presents the full word for one cycle. Assumes byte_we is already gated.
module fww_pair (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        byte_we,
    input  logic [7:0]  byte_in,
    output logic        half_held,
    output logic        word_valid,
    output logic [15:0] word_out
);
    logic [7:0] low_q;

    // Present the word when the second byte arrives.
    always_comb begin
        word_valid = byte_we && half_held && !clear;
        word_out   = {byte_in, low_q};
    end

    // Track which half comes next and store the low byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_held <= 1'b0;
            low_q     <= '0;
        end else if (clear) begin
            half_held <= 1'b0;
        end else if (byte_we) begin
            if (!half_held) low_q <= byte_in;
            half_held <= !half_held;
        end
    end
endmodule

// File: rtl/fww_timeout.sv
// Data watchdog: counts cycles while armed and flags expiry in the last
// cycle of a LIMIT-cycle window. Assumes LIMIT >= 2.
module fww_timeout #(
    parameter int LIMIT = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    logic [CW-1:0] cnt_q;

    // Expiry when the window's last cycle is reached while armed.
    always_comb expired = run && !restart && (cnt_q == CW'(LIMIT - 1));

    // Count armed cycles, restarting on request.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (restart)           cnt_q <= '0;
        else if (run && !expired)   cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/fww_prog.sv
// Program-time model: busy for CYCLES cycles after start, with a done
// pulse in the final busy cycle. Assumes start only arrives while idle.
module fww_prog #(
    parameter int CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);
    logic [CW-1:0] left_q;

    // Busy while cycles remain; done on the last one.
    always_comb begin
        busy = (left_q != '0);
        done = (left_q == CW'(1));
    end

    // Load the duration on start and count it down.
    always_ff @(posedge clk) begin
        if (!rst_n)      left_q <= '0;
        else if (start)  left_q <= CW'(CYCLES);
        else if (busy)   left_q <= left_q - 1'b1;
    end
endmodule

// File: rtl/flash_word_writer.sv
// Flash word write controller: register interface, byte pairing, word
// address advance, data watchdog and DMA request. Assumes the array
// latches fl_addr/fl_data on fl_prog and needs PROG_CYCLES to finish.
module flash_word_writer #(
    parameter int CLK_HZ      = 250_000_000,
    parameter int TIMEOUT_US  = 40,
    parameter int TMO_CYCLES  = (CLK_HZ / 1_000_000) * TIMEOUT_US,
    parameter int PROG_CYCLES = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_we,
    input  logic [1:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        fl_prog,
    output logic [15:0] fl_addr,
    output logic [15:0] fl_data,
    output logic        dma_req,
    output logic [4:0]  dma_trig
);
    import fww_pkg::*;

    logic        active;
    logic [15:0] word_addr;
    logic        word_busy, prog_done, expired;
    logic        half_held, word_valid;
    logic [15:0] word_out;
    logic        wr_ctrl, go_set, go_clr, byte_we, pair_clear;

    // Decode register writes into sequence events.
    always_comb begin
        wr_ctrl    = bus_we && (bus_addr == REG_CTRL);
        go_set     = wr_ctrl && bus_wdata[CTRL_GO_BIT];
        go_clr     = wr_ctrl && !bus_wdata[CTRL_GO_BIT] && !word_busy;
        byte_we    = bus_we && (bus_addr == REG_DATA) && active
                     && !word_busy && !expired;
        pair_clear = go_set || go_clr || expired;
    end

    fww_pair u_pair (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (pair_clear),
        .byte_we    (byte_we),
        .byte_in    (bus_wdata),
        .half_held  (half_held),
        .word_valid (word_valid),
        .word_out   (word_out)
    );

    fww_timeout #(.LIMIT(TMO_CYCLES)) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (go_set || prog_done),
        .run     (active && !word_busy),
        .expired (expired)
    );

    fww_prog #(.CYCLES(PROG_CYCLES)) u_prog (
        .clk   (clk),
        .rst_n (rst_n),
        .start (word_valid),
        .busy  (word_busy),
        .done  (prog_done)
    );

    // Sequence state: start, software end, or watchdog abort.
    always_ff @(posedge clk) begin
        if (!rst_n)                  active <= 1'b0;
        else if (go_set)             active <= 1'b1;
        else if (expired || go_clr)  active <= 1'b0;
    end

    // Word address: software load while idle, advance after each word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_addr <= '0;
        end else if (prog_done) begin
            word_addr <= word_addr + 1'b1;
        end else if (bus_we && !active) begin
            if (bus_addr == REG_ADDR_LO) word_addr[7:0]  <= bus_wdata;
            if (bus_addr == REG_ADDR_HI) word_addr[15:8] <= bus_wdata;
        end
    end

    // Register the program strobe and its data towards the array.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fl_prog <= 1'b0;
            fl_data <= '0;
        end else begin
            fl_prog <= word_valid;
            if (word_valid) fl_data <= word_out;
        end
    end

    // Array address, DMA request and register readback.
    always_comb begin
        fl_addr  = word_addr;
        dma_req  = active && !word_busy && !half_held;
        dma_trig = dma_req ? DMA_TRIG_FLASH : 5'b00000;
        unique case (bus_addr)
            REG_CTRL:    bus_rdata = {6'b0, word_busy, active};
            REG_DATA:    bus_rdata = 8'h00;
            REG_ADDR_LO: bus_rdata = word_addr[7:0];
            default:     bus_rdata = word_addr[15:8];
        endcase
    end
endmodule

// File: rtl/fww_checker.sv
// Temporal checks on the flash word write controller, bound to its top.
module fww_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        active,
    input logic        word_busy,
    input logic [15:0] word_addr,
    input logic        fl_prog,
    input logic        dma_req
);
    // R3: one strobe per word.
    p_single_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fl_prog |=> !fl_prog);
    // R4: the array is busy while its strobe is being served.
    p_busy_with_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fl_prog |-> word_busy);
    // R4: no DMA request while a word programs.
    p_dma_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        word_busy |-> !dma_req);
    // R5: completion advances the address by one.
    p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(word_busy) |-> (word_addr == $past(word_addr) + 16'd1));
    // R6: no strobe without an active sequence.
    p_no_idle_prog_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !fl_prog);
    // R7: ending a sequence leaves the address alone.
    p_abort_keeps_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> $stable(word_addr));
endmodule

bind flash_word_writer fww_checker u_fww_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (active),
    .word_busy (word_busy),
    .word_addr (word_addr),
    .fl_prog   (fl_prog),
    .dma_req   (dma_req)
);

// File: tb/flash_word_writer_tb.sv
module flash_word_writer_tb;
    localparam int TMO  = 60;
    localparam int PROG = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [7:0]  bus_wdata = 8'd0;
    logic [7:0]  bus_rdata;
    logic        fl_prog;
    logic [15:0] fl_addr, fl_data;
    logic        dma_req;
    logic [4:0]  dma_trig;

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_q[$];
    logic [15:0] exp_addr = 16'h0;
    logic [7:0]  rv;

    always #2 clk = ~clk;

    flash_word_writer #(.TMO_CYCLES(TMO), .PROG_CYCLES(PROG)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fl_prog(fl_prog),
        .fl_addr(fl_addr), .fl_data(fl_data), .dma_req(dma_req),
        .dma_trig(dma_trig)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // Driver: pushes the expected strobe, then writes both bytes.
    task automatic put_word(input logic [7:0] lo, input logic [7:0] hi);
        exp_q.push_back({exp_addr, hi, lo});
        wr(2'd1, lo);
        wr(2'd1, hi);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 40; i++) begin
            rd(2'd0, rv);
            if (!rv[1]) break;
        end
    endtask

    task automatic chk_addr(input string req, input logic [15:0] e);
        logic [7:0] lo, hi;
        rd(2'd2, lo);
        rd(2'd3, hi);
        chk({hi, lo} == e, req, {hi, lo}, e);
    endtask

    // Monitor: every strobe must match the head of the queue.
    always @(negedge clk) begin
        if (rst_n && fl_prog) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6 unexpected strobe", {fl_addr, fl_data}, 0);
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                chk({fl_addr, fl_data} == e, "R3 strobe word", {fl_addr, fl_data}, e);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(2'd0, rv); chk(rv == 8'h00, "R1 ctrl reset", rv, 0);
        chk_addr("R1 addr reset", 16'h0);
        chk(dma_req == 1'b0, "R1 dma reset", dma_req, 0);
        // R10 address load while idle
        wr(2'd2, 8'h10); wr(2'd3, 8'h02); exp_addr = 16'h0210;
        chk_addr("R10 addr load idle", 16'h0210);
        rd(2'd1, rv); chk(rv == 8'h00, "R1 data reads 0", rv, 0);
        // R2 start
        wr(2'd0, 8'h01);
        rd(2'd0, rv); chk(rv == 8'h01, "R2 go reads 1", rv, 1);
        chk(dma_req && dma_trig == 5'b10010, "R2 dma trig", {dma_req, dma_trig}, 6'h32);
        // R10 address write ignored while active
        wr(2'd2, 8'hFF);
        chk_addr("R10 addr ignored active", 16'h0210);
        // R3/R4 pairing
        exp_q.push_back({exp_addr, 16'h3CA5});
        wr(2'd1, 8'hA5);
        chk(dma_req == 1'b0, "R4 dma low half held", dma_req, 0);
        wr(2'd1, 8'h3C);
        rd(2'd0, rv); chk(rv == 8'h03, "R4 wbusy high", rv, 3);
        chk(dma_req == 1'b0, "R4 dma low busy", dma_req, 0);
        // R6 byte during busy dropped
        wr(2'd1, 8'h77);
        // R9 clear during busy ignored
        wr(2'd0, 8'h00);
        rd(2'd0, rv); chk(rv[0] == 1'b1, "R9 clear ignored busy", rv, 1);
        wait_idle();
        exp_addr = 16'h0211;
        chk_addr("R5 addr advance", exp_addr);
        put_word(8'h11, 8'h22);
        wait_idle();
        exp_addr = 16'h0212;
        // R9 clear while idle
        wr(2'd0, 8'h00);
        rd(2'd0, rv); chk(rv == 8'h00, "R9 clear idle", rv, 0);
        chk(dma_req == 1'b0, "R2 dma low inactive", dma_req, 0);
        // R6 data while inactive dropped
        wr(2'd1, 8'hDE); wr(2'd1, 8'hAD);
        chk_addr("R6 addr unchanged inactive", exp_addr);
        // R7 timeout with half word
        wr(2'd0, 8'h01);
        wr(2'd1, 8'h99);
        repeat (TMO + 5) @(negedge clk);
        rd(2'd0, rv); chk(rv == 8'h00, "R7 abort half word", rv, 0);
        chk_addr("R7 addr retained", exp_addr);
        // R8 resume, stray byte discarded
        wr(2'd0, 8'h01);
        put_word(8'h44, 8'h55);
        wait_idle();
        exp_addr = 16'h0213;
        // R7 timeout after a completed word
        repeat (TMO + 5) @(negedge clk);
        rd(2'd0, rv); chk(rv == 8'h00, "R7 abort after word", rv, 0);
        chk_addr("R7 addr after word", exp_addr);
        // R5 carry into high register
        wr(2'd2, 8'hFF); wr(2'd3, 8'h00); exp_addr = 16'h00FF;
        wr(2'd0, 8'h01);
        put_word(8'h5A, 8'hC3);
        wait_idle();
        exp_addr = 16'h0100;
        chk_addr("R5 carry", exp_addr);
        wr(2'd0, 8'h00);
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R3 all strobes seen", exp_q.size(), 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule